// File: doc/BRIEF.md
# Segment Attribute Register Bank

This block holds one attribute register for every 16 MB slice of a 32-bit address space, 256 registers in all. Each register carries two meaningful flags: a cacheable flag and a prefetchable flag. Software programs the registers through a simple register port with a write enable, an index, write data and read data. Cache and prefetch logic elsewhere present an address on a lookup port and receive that slice's two flags in the same cycle.

The sixteen lowest slices describe on-chip memory, and their registers are locked: writes to them are dropped and they always read zero. Every other register keeps only the two flag bits of a write, and every other bit reads as zero. Internally only the two flag bits of each writable register are stored; the 32-bit read word is rebuilt from them.

Top module: `mab_bank`

## Requirements
- R1: After reset every register reads 0x0000_0000 and both lookup flags are 0 for every address.
- R2: A write to any register with index 0 to 15 is ignored; that register still reads 0x0000_0000 afterwards.
- R3: A write to a register with index 16 to 255 stores write-data bit 0 into register bit 0 and write-data bit 3 into register bit 3.
- R4: Register bits other than bit 0 and bit 3 always read 0, whatever was written.
- R5: The lookup uses address bits [31:24] as the register index, so addresses 0xNN00_0000 through 0xNNFF_FFFF all map to register NN.
- R6: `lk_cacheable` equals bit 0 of the register selected by the lookup address.
- R7: `lk_prefetchable` equals bit 3 of the register selected by the lookup address.
- R8: Read data and lookup outputs are combinational from the stored contents; a write taken on a clock edge shows on both from the cycle after that edge, and not in the cycle the write is presented.
- R9: Any lookup address below 0x1000_0000 returns both flags as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_idx | input | 8 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Current contents of register `cfg_idx` |
| lk_addr | input | 32 | Lookup address |
| lk_cacheable | output | 1 | Cacheable flag of the slice holding `lk_addr` |
| lk_prefetchable | output | 1 | Prefetchable flag of the slice holding `lk_addr` |

## Verification
The bench writes all-ones into the locked registers and at the 15/16 boundary, where a wrong bound would either lock register 16 or let register 15 take data. It writes patterns with only reserved bits set, which a design storing the full word would echo back, and checks bit 0 and bit 3 separately so swapped flag positions show up on the lookup outputs. It reads a register in the same cycle as its write and the next cycle, catching a design that forwards write data early or lags a cycle, and probes addresses at both ends of a slice so a wrong address slice for the index is exposed.

// File: rtl/mab_pkg.sv
package mab_pkg;

    localparam int NUM_SEGS  = 256;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int RO_SEGS   = 16;
    localparam int CACHE_POS = 0;
    localparam int PREF_POS  = 3;
    localparam int IDX_W     = $clog2(NUM_SEGS);

    typedef logic [IDX_W-1:0]  seg_idx_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    // Stored state of one writable slice register
    typedef struct packed {
        logic pref;
        logic cache;
    } seg_attr_t;

    // Pull the two meaningful flags out of a bus word
    function automatic seg_attr_t word_to_attr(word_t w);
        seg_attr_t a;
        a.cache = w[CACHE_POS];
        a.pref  = w[PREF_POS];
        return a;
    endfunction

    // Rebuild the architectural word; reserved bits are zero
    function automatic word_t attr_to_word(seg_attr_t a);
        word_t w;
        w            = '0;
        w[CACHE_POS] = a.cache;
        w[PREF_POS]  = a.pref;
        return w;
    endfunction

    // Index of the slice that holds an address: its top bits
    function automatic seg_idx_t addr_to_seg(addr_t a);
        return a[ADDR_W-1 -: IDX_W];
    endfunction

    function automatic logic seg_is_locked(seg_idx_t i);
        return (int'(i) < RO_SEGS);
    endfunction

endpackage

// File: rtl/mab_attr_store.sv
module mab_attr_store
    import mab_pkg::*;
#(
    parameter int N_SEGS  = NUM_SEGS,
    parameter int N_RO    = RO_SEGS,
    localparam int IW     = $clog2(N_SEGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IW-1:0]              wr_idx,
    input  seg_attr_t                  wr_attr,
    output seg_attr_t [N_SEGS-1:0]     attr_q
);

    for (genvar g = 0; g < N_SEGS; g++) begin : g_seg
        if (g < N_RO) begin : g_locked
            // On-chip slices: no storage, constant zero
            assign attr_q[g] = '0;
        end else begin : g_rw
            logic hit;
            assign hit = wr_en && (wr_idx == IW'(g));
            always_ff @(posedge clk) begin
                if (rst) begin
                    attr_q[g] <= '0;
                end else if (hit) begin
                    attr_q[g] <= wr_attr;
                end
            end
        end
    end

endmodule

// File: rtl/mab_word_view.sv
module mab_word_view
    import mab_pkg::*;
#(
    parameter int N_SEGS = NUM_SEGS,
    localparam int IW    = $clog2(N_SEGS)
) (
    input  seg_attr_t [N_SEGS-1:0] attr_q,
    input  logic [IW-1:0]          rd_idx,
    output word_t                  rd_word
);

    seg_attr_t sel;

    always_comb begin
        sel     = attr_q[rd_idx];
        rd_word = attr_to_word(sel);
    end

endmodule

// File: rtl/mab_seg_lookup.sv
module mab_seg_lookup
    import mab_pkg::*;
#(
    parameter int N_SEGS = NUM_SEGS
) (
    input  seg_attr_t [N_SEGS-1:0] attr_q,
    input  addr_t                  addr,
    output seg_attr_t              attr
);

    seg_idx_t seg;

    always_comb begin
        seg  = addr_to_seg(addr);
        attr = attr_q[seg];
    end

endmodule

// File: rtl/mab_bank.sv
module mab_bank
    import mab_pkg::*;
#(
    parameter int N_SEGS = NUM_SEGS,
    parameter int N_RO   = RO_SEGS,
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W,
    localparam int IW    = $clog2(N_SEGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_idx,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_cacheable,
    output logic          lk_prefetchable
);

    seg_attr_t [N_SEGS-1:0] attr_q;
    seg_attr_t              wr_attr;
    seg_attr_t              lk_attr;
    logic                   wr_ok;

    // Locked slices drop the write before it reaches storage
    assign wr_attr = word_to_attr(cfg_wdata);
    assign wr_ok   = cfg_we && !seg_is_locked(cfg_idx);

    mab_attr_store #(.N_SEGS(N_SEGS), .N_RO(N_RO)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok),
        .wr_idx  (cfg_idx),
        .wr_attr (wr_attr),
        .attr_q  (attr_q)
    );

    mab_word_view #(.N_SEGS(N_SEGS)) u_view (
        .attr_q  (attr_q),
        .rd_idx  (cfg_idx),
        .rd_word (cfg_rdata)
    );

    mab_seg_lookup #(.N_SEGS(N_SEGS)) u_lookup (
        .attr_q (attr_q),
        .addr   (lk_addr),
        .attr   (lk_attr)
    );

    assign lk_cacheable    = lk_attr.cache;
    assign lk_prefetchable = lk_attr.pref;

    // Reserved bits never show on the read port
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~((DW'(1) << CACHE_POS) | (DW'(1) << PREF_POS))) == '0); // R4

    // A locked register does not change under a write
    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (int'(cfg_idx) < N_RO)) |=> (!$stable(cfg_idx) || $stable(cfg_rdata))); // R2

    // A writable register shows the two flag bits one cycle after the write
    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (int'(cfg_idx) >= N_RO)) |=> (!$stable(cfg_idx) ||
            (cfg_rdata[CACHE_POS] == $past(cfg_wdata[CACHE_POS]) &&
             cfg_rdata[PREF_POS]  == $past(cfg_wdata[PREF_POS])))); // R3

    // Read path and lookup path agree on cacheable for the same slice
    AST_LOOKUP_CACHE: assert property (@(posedge clk) disable iff (rst)
        (lk_addr[AW-1 -: IW] == cfg_idx) |-> (lk_cacheable == cfg_rdata[CACHE_POS])); // R6

    AST_LOOKUP_PREF: assert property (@(posedge clk) disable iff (rst)
        (lk_addr[AW-1 -: IW] == cfg_idx) |-> (lk_prefetchable == cfg_rdata[PREF_POS])); // R7

    // On-chip slices never report a flag
    AST_LOW_SEG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (int'(lk_addr[AW-1 -: IW]) < N_RO) |-> (!lk_cacheable && !lk_prefetchable)); // R9

endmodule

// File: tb/sim_mab_bank.sv
module sim_mab_bank;

    localparam int N_SEGS = 256;
    localparam int N_RO   = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] lk_addr = '0;
    logic        lk_cacheable;
    logic        lk_prefetchable;

    always #2 clk = ~clk; // 250 MHz

    mab_bank u0 (
        .clk             (clk),
        .rst             (rst),
        .cfg_we          (cfg_we),
        .cfg_idx         (cfg_idx),
        .cfg_wdata       (cfg_wdata),
        .cfg_rdata       (cfg_rdata),
        .lk_addr         (lk_addr),
        .lk_cacheable    (lk_cacheable),
        .lk_prefetchable (lk_prefetchable)
    );

    typedef struct {
        bit          is_lookup;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic [31:0] model [N_SEGS];
    int          n_run  = 0;
    int          n_fail = 0;
    int          cycles = 0;
    bit          done   = 0;

    // Monitor: one expected item per cycle, compared away from the edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_lookup ? {30'd0, lk_prefetchable, lk_cacheable} : cfg_rdata;
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic clear_model();
        for (int i = 0; i < N_SEGS; i++) model[i] = '0;
    endtask

    task automatic probe_reg(input int idx, input string tag);
        item_t it;
        @(posedge clk); #1;
        cfg_we  = 1'b0;
        cfg_idx = idx[7:0];
        it.is_lookup = 0; it.exp = model[idx]; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic probe_addr(input logic [31:0] a, input string tag);
        item_t it;
        int    s;
        @(posedge clk); #1;
        cfg_we  = 1'b0;
        lk_addr = a;
        s = int'(a[31:24]);
        it.is_lookup = 1; it.exp = {30'd0, model[s][3], model[s][0]}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Write with a same-cycle read of the old value (R8), then model update
    task automatic write_reg(input int idx, input logic [31:0] d);
        item_t it;
        @(posedge clk); #1;
        cfg_we    = 1'b1;
        cfg_idx   = idx[7:0];
        cfg_wdata = d;
        it.is_lookup = 0; it.exp = model[idx]; it.tag = "R8 old value in write cycle";
        sb_q.push_back(it);
        if (idx >= N_RO) model[idx] = d & 32'h0000_0009;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        cfg_we = 1'b0;
        rst    = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        clear_model();
    endtask

    initial begin
        clear_model();
        do_reset();

        // R1: everything clear after reset
        for (int i = 0; i < N_SEGS; i++) probe_reg(i, "R1 reset read");
        probe_addr(32'hFFFF_FFFF, "R1 reset lookup");
        probe_addr(32'h8000_0000, "R1 reset lookup");

        // R2: locked registers ignore writes, incl. boundary 15
        for (int i = 0; i < N_RO; i++) write_reg(i, 32'hFFFF_FFFF);
        for (int i = 0; i < N_RO; i++) probe_reg(i, "R2 locked readback");

        // R3/R4 at boundary 16 and elsewhere
        write_reg(16, 32'hFFFF_FFFF);
        probe_reg(16, "R3 R8 idx16 next cycle");
        write_reg(255, 32'h0000_0008);
        probe_reg(255, "R3 pref only");
        write_reg(100, 32'h0000_0001);
        probe_reg(100, "R3 cache only");
        write_reg(200, 32'hFFFF_FFF6);
        probe_reg(200, "R4 reserved only");
        write_reg(17, 32'h0000_0009);
        write_reg(17, 32'h0000_0000);
        probe_reg(17, "R3 overwrite to zero");

        // R5-R7 lookups, both ends of a slice
        probe_addr(32'h1000_0000, "R5 R6 R7 slice16 low end");
        probe_addr(32'h10FF_FFFF, "R5 slice16 high end");
        probe_addr(32'hFF12_3456, "R7 slice255 pref");
        probe_addr(32'h6400_0000, "R6 slice100 cache");
        probe_addr(32'hC8AB_CDEF, "R4 slice200 no flags");
        probe_addr(32'h0FFF_FFFF, "R9 slice15 boundary");
        probe_addr(32'h0A00_1234, "R9 low slice");
        probe_addr(32'h0000_0000, "R9 slice0");

        // R8: write and lookup next cycle
        write_reg(50, 32'h0000_0008);
        probe_addr(32'h3200_0000, "R8 lookup after write");

        // Random traffic, then full sweep
        for (int k = 0; k < 400; k++) write_reg(int'($urandom_range(0, 255)), $urandom());
        for (int i = 0; i < N_SEGS; i++) probe_reg(i, "R3 R4 random sweep");
        for (int i = 0; i < N_SEGS; i++) probe_addr({i[7:0], 24'h5A5A5A}, "R5 R6 R7 random lookup");

        // R1: reset mid-run clears everything
        do_reset();
        for (int i = 0; i < N_SEGS; i++) probe_reg(i, "R1 reset after traffic");
        probe_addr(32'hFF00_0000, "R1 lookup after reset");

        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule